// File: doc/BRIEF.md
# Command Ring Fetch Controller

This block runs a circular command ring that sits in system memory. Software sets the ring's location and size, turns the block on, and moves a producer offset forward as it adds commands. The block then reads the ring one 32-byte slot at a time and works out what each command needs. It passes commands that need real work to an external handler and moves its consumer offset forward once the handler says to continue. A failed fetch or a stall answer from the handler latches a sticky stalled flag, and the ring freezes until software rewrites the consumer offset.

The register port accepts 64-bit writes and 32-bit writes to either half. It has four registers, picked by a 2-bit select:

| Select | Register |
|--------|----------|
| 0 | Control. Bit 0 is the enable. |
| 1 | Ring location. Bits [7:0] hold the page count minus one. Bits [51:12] hold the 4 KB-aligned physical address. |
| 2 | Producer offset |
| 3 | Consumer offset |

Both offset registers keep the entry index in bits [19:5], so the value read is a byte offset. Bit 0 is the retry bit in the producer register and the stalled flag in the consumer register.

The memory read port and the handler request port both use valid/ready. Once valid is raised, the requester holds it high, with address or payload unchanged, until ready is seen. The memory response and the handler result are single-cycle strobes with no back-pressure. The block keeps at most one fetch or one handler request outstanding, so it always accepts them. A response counts only in the state that waits for it.

Top module: `cmdq_ctrl`

## Requirements
- R1: After reset, all four registers read zero. Memory request, handler request and recalc outputs are all low.
- R2: The ring holds (page count field + 1) × 4096 / 32 entries. No fetch starts while either offset is equal to or above that length.
- R3: Each fetch reads address {physical address field, 12'b0} + consumer index × 32. Bits of the location register outside the two fields have no effect. Valid and address stay stable until ready.
- R4: The opcode is bits [7:0] of the fetched word. Opcodes 0x03, 0x04, 0x08, 0x09, 0x0A, 0x0B and 0x0F go to the handler with that opcode and the full word. The handler request holds until accepted and never overlaps a fetch.
- R5: On a continue outcome, the consumer index goes up by one and wraps from length−1 to 0.
- R6: A fetch error, or a handler result with stall set, sets consumer bit 0 and leaves the index unchanged. No further fetch starts while bit 0 is set.
- R7: No fetch starts while the enable bit is clear, even when the offsets differ.
- R8: The location register takes writes only while disabled. An accepted write also copies the consumer index into the producer register. Writes while enabled are ignored.
- R9: Writes to the producer register clear bit 0 whenever the low half is written. Either 32-bit half can be written on its own.
- R10: The consumer register takes writes only while the security-disable input is high, and then bit 0 is cleared. At other times the write is ignored.
- R11: Opcode 0x05 and any opcode not in the R4 list complete without a handler request. Opcode 0x0D completes without a handler request and drives all recalc bits high for exactly one cycle.
- R12: The block returns to idle when the two indices match. It starts no further fetch until the producer moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Allows writes to the consumer register |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register written: 0 control, 1 location, 2 producer, 3 consumer |
| reg_wr_dw | input | 1 | 1 = 64-bit write |
| reg_wr_hi | input | 1 | For 32-bit writes: 1 = upper half |
| reg_wr_data | input | 64 | Write data. A 32-bit write uses bits [31:0]. |
| reg_rd_sel | input | 2 | Register read back |
| reg_rd_data | output | 64 | Read data for the selected register |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | ADDR_W | Fetch byte address |
| mem_rsp_valid | input | 1 | Fetch data strobe |
| mem_rsp_err | input | 1 | Fetch failed |
| mem_rsp_data | input | 64 | First 64-bit word of the command |
| hnd_req_valid | output | 1 | Handler request valid |
| hnd_req_ready | input | 1 | Handler accepts the command |
| hnd_req_opcode | output | 8 | Opcode of the command |
| hnd_req_word | output | 64 | Full fetched word |
| hnd_rsp_valid | input | 1 | Handler result strobe |
| hnd_rsp_stall | input | 1 | Result: 1 = stall, 0 = continue |
| recalc | output | NUM_CPU | One-cycle recalculation pulse, one bit per processor |

## Verification
The assertions check these rules on every cycle:
- fetch and handler requests hold steady under back-pressure and never overlap;
- a fetch only starts when the previous cycle had the block enabled, unstalled and with both offsets in range;
- the recalc pulse is all ones and lasts a single cycle.

Only the bench's scenarios can show:
- the exact fetch addresses;
- the consumer index wrapping at the length set by the page count;
- the opcode routing across all 256 opcode values;
- the masking of bit 0 on register writes;
- the gating of location and consumer writes;
- the copy of the consumer index into the producer register.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_WPTR = 2'd2,
    SEL_RPTR = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT_MEM,
    ST_DISPATCH,
    ST_WAIT_HND
  } seq_state_e;

  localparam logic [7:0] OP_SYNC   = 8'h05;
  localparam logic [7:0] OP_INVALL = 8'h0D;

  // Opcodes that need the external handler; everything else completes locally.
  function automatic logic needs_handler(input logic [7:0] op);
    logic hit;
    case (op)
      8'h03, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0F: hit = 1'b1;
      default:                                         hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int OFF_LSB = 5,
  parameter int OFF_W   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_disable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic             wr_dw,
  input  logic             wr_hi,
  input  logic [63:0]      wr_data,
  input  logic [1:0]       rd_sel,
  output logic [63:0]      rd_data,
  input  logic             adv,
  input  logic [OFF_W-1:0] adv_off,
  input  logic             set_stall,
  output logic             enable,
  output logic [63:0]      base_q,
  output logic [OFF_W-1:0] wr_off,
  output logic [OFF_W-1:0] rd_off,
  output logic             stalled
);

  localparam logic [63:0] OFF_MASK = ((64'd1 << OFF_W) - 64'd1) << OFF_LSB;

  logic        en_q;
  logic [63:0] base_r;
  logic [63:0] wptr_r;
  logic [63:0] rptr_r;
  logic        low_touched;
  logic [63:0] bit0_clr;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] data,
                                        input logic dw, input logic hi);
    logic [63:0] res;
    if (dw)      res = data;
    else if (hi) res = {data[31:0], old[31:0]};
    else         res = {old[63:32], data[31:0]};
    return res;
  endfunction

  assign low_touched = wr_dw || !wr_hi;
  assign bit0_clr    = ~{63'd0, low_touched};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_r <= '0;
      wptr_r <= '0;
      rptr_r <= '0;
    end else begin
      // Sequencer updates first; a software write in the same cycle wins.
      if (adv)       rptr_r[OFF_LSB +: OFF_W] <= adv_off;
      if (set_stall) rptr_r[0] <= 1'b1;
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_CTL: if (low_touched) en_q <= wr_data[0];
          SEL_BASE: begin
            if (!en_q) begin
              base_r <= merge(base_r, wr_data, wr_dw, wr_hi);
              wptr_r <= rptr_r & OFF_MASK;
            end
          end
          SEL_WPTR: wptr_r <= merge(wptr_r, wr_data, wr_dw, wr_hi) & bit0_clr;
          SEL_RPTR: begin
            if (sec_disable) rptr_r <= merge(rptr_r, wr_data, wr_dw, wr_hi) & bit0_clr;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CTL:  rd_data = {63'd0, en_q};
      SEL_BASE: rd_data = base_r;
      SEL_WPTR: rd_data = wptr_r;
      default:  rd_data = rptr_r;
    endcase
  end

  assign enable  = en_q;
  assign base_q  = base_r;
  assign wr_off  = wptr_r[OFF_LSB +: OFF_W];
  assign rd_off  = rptr_r[OFF_LSB +: OFF_W];
  assign stalled = rptr_r[0];

endmodule

// File: rtl/cmdq_geom.sv
module cmdq_geom #(
  parameter int ADDR_W    = 52,
  parameter int PA_LSB    = 12,
  parameter int SIZE_W    = 8,
  parameter int PG_SHIFT  = 7,
  parameter int ENT_SHIFT = 5,
  parameter int OFF_W     = 15
) (
  input  logic [SIZE_W-1:0]        size_fld,
  input  logic [ADDR_W-PA_LSB-1:0] pa_fld,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [OFF_W-1:0]         rd_off,
  output logic                     range_ok,
  output logic [ADDR_W-1:0]        fetch_addr,
  output logic [OFF_W-1:0]         next_off
);

  localparam int LEN_W = OFF_W + 1;

  logic [LEN_W-1:0] qlen;
  logic [LEN_W-1:0] inc;

  assign qlen     = (LEN_W'(size_fld) + LEN_W'(1)) << PG_SHIFT;
  assign range_ok = ({1'b0, wr_off} < qlen) && ({1'b0, rd_off} < qlen);
  assign inc      = {1'b0, rd_off} + LEN_W'(1);
  assign next_off = (inc == qlen) ? '0 : inc[OFF_W-1:0];

  assign fetch_addr = {pa_fld, {PA_LSB{1'b0}}}
                    + ADDR_W'({rd_off, {ENT_SHIFT{1'b0}}});

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int ADDR_W  = 52,
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ok,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [63:0]        mem_rsp_data,
  output logic               hnd_req_valid,
  input  logic               hnd_req_ready,
  output logic [7:0]         hnd_req_opcode,
  output logic [63:0]        hnd_req_word,
  input  logic               hnd_rsp_valid,
  input  logic               hnd_rsp_stall,
  output logic [NUM_CPU-1:0] recalc,
  output logic               adv,
  output logic               set_stall
);

  seq_state_e          state;
  logic [ADDR_W-1:0]   addr_q;
  logic [63:0]         word_q;
  logic [NUM_CPU-1:0]  recalc_q;
  logic                mem_done;
  logic                hnd_done;
  logic                rsp_to_hnd;

  assign mem_done   = (state == ST_WAIT_MEM) && mem_rsp_valid;
  assign hnd_done   = (state == ST_WAIT_HND) && hnd_rsp_valid;
  assign rsp_to_hnd = needs_handler(mem_rsp_data[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      word_q   <= '0;
      recalc_q <= '0;
    end else begin
      recalc_q <= '0;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            addr_q <= fetch_addr;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT_MEM;
        ST_WAIT_MEM: begin
          if (mem_rsp_valid) begin
            word_q <= mem_rsp_data;
            if (mem_rsp_err) begin
              state <= ST_IDLE;
            end else if (rsp_to_hnd) begin
              state <= ST_DISPATCH;
            end else begin
              state <= ST_IDLE;
              if (mem_rsp_data[7:0] == OP_INVALL) recalc_q <= '1;
            end
          end
        end
        ST_DISPATCH: if (hnd_req_ready) state <= ST_WAIT_HND;
        ST_WAIT_HND: if (hnd_rsp_valid) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    adv       = (mem_done && !mem_rsp_err && !rsp_to_hnd) || (hnd_done && !hnd_rsp_stall);
    set_stall = (mem_done && mem_rsp_err) || (hnd_done && hnd_rsp_stall);
  end

  assign mem_req_valid  = (state == ST_FETCH);
  assign mem_req_addr   = addr_q;
  assign hnd_req_valid  = (state == ST_DISPATCH);
  assign hnd_req_opcode = word_q[7:0];
  assign hnd_req_word   = word_q;
  assign recalc         = recalc_q;

endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl #(
  parameter int ADDR_W      = 52,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 32,
  parameter int SIZE_W      = 8,
  parameter int NUM_CPU     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_disable,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_wr_sel,
  input  logic               reg_wr_dw,
  input  logic               reg_wr_hi,
  input  logic [63:0]        reg_wr_data,
  input  logic [1:0]         reg_rd_sel,
  output logic [63:0]        reg_rd_data,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [63:0]        mem_rsp_data,
  output logic               hnd_req_valid,
  input  logic               hnd_req_ready,
  output logic [7:0]         hnd_req_opcode,
  output logic [63:0]        hnd_req_word,
  input  logic               hnd_rsp_valid,
  input  logic               hnd_rsp_stall,
  output logic [NUM_CPU-1:0] recalc
);

  localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
  localparam int PA_LSB    = $clog2(PAGE_BYTES);
  localparam int PG_SHIFT  = PA_LSB - ENT_SHIFT;
  localparam int OFF_W     = SIZE_W + PG_SHIFT;

  logic [63:0]       base_q;
  logic [OFF_W-1:0]  wr_off;
  logic [OFF_W-1:0]  rd_off;
  logic [OFF_W-1:0]  next_off;
  logic              enable_q;
  logic              stalled_q;
  logic              range_ok;
  logic [ADDR_W-1:0] fetch_addr;
  logic              adv;
  logic              set_stall;
  logic              start_ok;

  cmdq_regs #(.OFF_LSB(ENT_SHIFT), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_dw(reg_wr_dw), .wr_hi(reg_wr_hi),
    .wr_data(reg_wr_data), .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .adv(adv), .adv_off(next_off), .set_stall(set_stall),
    .enable(enable_q), .base_q(base_q), .wr_off(wr_off), .rd_off(rd_off),
    .stalled(stalled_q)
  );

  cmdq_geom #(
    .ADDR_W(ADDR_W), .PA_LSB(PA_LSB), .SIZE_W(SIZE_W),
    .PG_SHIFT(PG_SHIFT), .ENT_SHIFT(ENT_SHIFT), .OFF_W(OFF_W)
  ) u_geom (
    .size_fld(base_q[SIZE_W-1:0]), .pa_fld(base_q[ADDR_W-1:PA_LSB]),
    .wr_off(wr_off), .rd_off(rd_off), .range_ok(range_ok),
    .fetch_addr(fetch_addr), .next_off(next_off)
  );

  assign start_ok = enable_q && !stalled_q && range_ok && (wr_off != rd_off);

  cmdq_seq #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .fetch_addr(fetch_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .hnd_req_valid(hnd_req_valid), .hnd_req_ready(hnd_req_ready),
    .hnd_req_opcode(hnd_req_opcode), .hnd_req_word(hnd_req_word),
    .hnd_rsp_valid(hnd_rsp_valid), .hnd_rsp_stall(hnd_rsp_stall),
    .recalc(recalc), .adv(adv), .set_stall(set_stall)
  );

endmodule

// File: rtl/cmdq_ctrl_chk.sv
module cmdq_ctrl_chk #(
  parameter int ADDR_W  = 52,
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               hnd_req_valid,
  input logic               hnd_req_ready,
  input logic [7:0]         hnd_req_opcode,
  input logic [NUM_CPU-1:0] recalc,
  input logic               en,
  input logic               stalled,
  input logic               range_ok
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_hnd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_req_valid && !hnd_req_ready) |=> (hnd_req_valid && $stable(hnd_req_opcode)));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && hnd_req_valid));

  p_fetch_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(en));

  p_fetch_unstalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(stalled));

  p_fetch_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(range_ok));

  p_recalc_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc != '0) |-> (&recalc));

  p_recalc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc != '0) |=> (recalc == '0));

endmodule

bind cmdq_ctrl cmdq_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .hnd_req_valid(hnd_req_valid), .hnd_req_ready(hnd_req_ready), .hnd_req_opcode(hnd_req_opcode),
  .recalc(recalc), .en(enable_q), .stalled(stalled_q), .range_ok(range_ok)
);

// File: tb/tb_cmdq_ctrl.sv
`timescale 1ns/1ps
module tb_cmdq_ctrl;

  localparam int ADDR_W  = 52;
  localparam int NUM_CPU = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sec_disable = 1'b0;
  logic               reg_wr_en = 1'b0;
  logic [1:0]         reg_wr_sel = '0;
  logic               reg_wr_dw = 1'b0;
  logic               reg_wr_hi = 1'b0;
  logic [63:0]        reg_wr_data = '0;
  logic [1:0]         reg_rd_sel = '0;
  logic [63:0]        reg_rd_data;
  logic               mem_req_valid;
  logic               mem_req_ready = 1'b0;
  logic [ADDR_W-1:0]  mem_req_addr;
  logic               mem_rsp_valid = 1'b0;
  logic               mem_rsp_err = 1'b0;
  logic [63:0]        mem_rsp_data = '0;
  logic               hnd_req_valid;
  logic               hnd_req_ready = 1'b0;
  logic [7:0]         hnd_req_opcode;
  logic [63:0]        hnd_req_word;
  logic               hnd_rsp_valid = 1'b0;
  logic               hnd_rsp_stall = 1'b0;
  logic [NUM_CPU-1:0] recalc;

  int compared = 0;
  int mismatched = 0;
  int len_exp = 128;
  logic [39:0] pa_exp = 40'h00ABCDE;

  always #2.5 clk = ~clk;

  cmdq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_dw(reg_wr_dw),
    .reg_wr_hi(reg_wr_hi), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .hnd_req_valid(hnd_req_valid), .hnd_req_ready(hnd_req_ready),
    .hnd_req_opcode(hnd_req_opcode), .hnd_req_word(hnd_req_word),
    .hnd_rsp_valid(hnd_rsp_valid), .hnd_rsp_stall(hnd_rsp_stall), .recalc(recalc)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit routed(input logic [7:0] op);
    return (op == 8'h03) || (op == 8'h04) || (op == 8'h08) || (op == 8'h09) ||
           (op == 8'h0A) || (op == 8'h0B) || (op == 8'h0F);
  endfunction

  task automatic wreg(input logic [1:0] sel, input bit dw, input bit hi, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_dw = dw; reg_wr_hi = hi; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [63:0] v);
    reg_rd_sel = sel;
    #1;
    v = reg_rd_data;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req_valid) seen = 1'b1;
    end
    chk(!seen, req, {63'd0, seen}, 64'd0);
  endtask

  task automatic serve(input int idx, input logic [7:0] op, input bit err, input bit stl);
    int waited = 0;
    logic [ADDR_W-1:0] ea;
    logic [63:0] word;
    logic [63:0] v;
    logic [63:0] exp_rd;
    bit disp;
    int nxt;
    ea   = {pa_exp, 12'h000} + ADDR_W'(idx * 32);
    word = {56'(idx * 3 + 7), op};
    disp = routed(op) && !err;
    while (!mem_req_valid && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    if (!mem_req_valid) begin
      chk(1'b0, "R3 fetch not issued", 64'd0, 64'd1);
      return;
    end
    chk(mem_req_addr == ea, "R3 fetch address", 64'(mem_req_addr), 64'(ea));
    @(negedge clk);
    chk(mem_req_valid && mem_req_addr == ea, "R3 request held while not ready",
        64'(mem_req_addr), 64'(ea));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = word; mem_rsp_err = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    if (disp) begin
      chk(hnd_req_valid && hnd_req_opcode == op && hnd_req_word == word,
          "R4 handler request", hnd_req_word, word);
      hnd_req_ready = 1'b1;
      @(negedge clk);
      hnd_req_ready = 1'b0;
      hnd_rsp_valid = 1'b1; hnd_rsp_stall = stl;
      @(negedge clk);
      hnd_rsp_valid = 1'b0; hnd_rsp_stall = 1'b0;
    end else begin
      chk(!hnd_req_valid, "R11 no handler request", {63'd0, hnd_req_valid}, 64'd0);
      chk(recalc == ((op == 8'h0D && !err) ? 4'hF : 4'h0), "R11 recalc pulse",
          64'(recalc), (op == 8'h0D && !err) ? 64'hF : 64'h0);
    end
    nxt    = (err || (disp && stl)) ? idx : (idx + 1) % len_exp;
    exp_rd = (64'(nxt) << 5) | ((err || (disp && stl)) ? 64'd1 : 64'd0);
    rreg(2'd3, v);
    chk(v == exp_rd, (err || stl) ? "R6 stall keeps index" : "R5 index advance", v, exp_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] base0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rreg(2'(s), v);
      chk(v == 64'd0, "R1 register reset", v, 64'd0);
    end
    chk(!mem_req_valid && !hnd_req_valid && recalc == '0, "R1 outputs idle",
        {62'd0, mem_req_valid, hnd_req_valid}, 64'd0);

    // R8 location write while disabled; junk bits must not steer the address (R3)
    base0 = 64'h8000_0000_0000_0F00 | ({24'd0, pa_exp} << 12);
    wreg(2'd1, 1'b1, 1'b0, base0);
    rreg(2'd1, v);
    chk(v == base0, "R8 location written while disabled", v, base0);

    wreg(2'd0, 1'b1, 1'b0, 64'd1);
    rreg(2'd0, v);
    chk(v == 64'd1, "R1 enable bit readback", v, 64'd1);

    // R9 split 32-bit producer write, retry bit dropped
    wreg(2'd2, 1'b0, 1'b1, 64'd0);
    wreg(2'd2, 1'b0, 1'b0, (64'd3 << 5) | 64'd1);
    rreg(2'd2, v);
    chk(v == (64'd3 << 5), "R9 retry bit cleared", v, 64'd3 << 5);

    serve(0, 8'h05, 1'b0, 1'b0);   // R11 sync
    serve(1, 8'h08, 1'b0, 1'b0);   // R4 routed
    serve(2, 8'h77, 1'b0, 1'b0);   // R11 unknown
    quiet(20, "R12 idle once indices match");

    // R8 location write ignored while enabled
    wreg(2'd1, 1'b1, 1'b0, 64'h1234_5678_0000_0003);
    rreg(2'd1, v);
    chk(v == base0, "R8 location locked while enabled", v, base0);

    wreg(2'd2, 1'b1, 1'b0, 64'd5 << 5);
    serve(3, 8'h0D, 1'b0, 1'b0);   // R11 invalidate-all
    serve(4, 8'h03, 1'b0, 1'b1);   // R6 stall result
    quiet(20, "R6 no fetch while stalled");

    // R10 consumer write gated by sec_disable
    wreg(2'd3, 1'b1, 1'b0, 64'd4 << 5);
    rreg(2'd3, v);
    chk(v == ((64'd4 << 5) | 64'd1), "R10 write ignored when not allowed", v, (64'd4 << 5) | 64'd1);
    sec_disable = 1'b1;
    wreg(2'd3, 1'b1, 1'b0, (64'd4 << 5) | 64'd1);
    rreg(2'd3, v);
    chk(v == (64'd4 << 5), "R10 stalled bit masked on write", v, 64'd4 << 5);
    serve(4, 8'h04, 1'b0, 1'b0);
    wreg(2'd2, 1'b1, 1'b0, 64'd7 << 5);
    serve(5, 8'h09, 1'b1, 1'b0);   // R6 fetch error

    // R7 disabled: no fetch although offsets differ
    wreg(2'd0, 1'b1, 1'b0, 64'd0);
    wreg(2'd3, 1'b1, 1'b0, 64'd5 << 5);
    quiet(20, "R7 no fetch while disabled");
    wreg(2'd1, 1'b1, 1'b0, base0);
    rreg(2'd2, v);
    chk(v == (64'd5 << 5), "R8 location write copies consumer index", v, 64'd5 << 5);

    // R5 wrap at the end of a one-page ring
    wreg(2'd3, 1'b1, 1'b0, 64'd127 << 5);
    wreg(2'd2, 1'b1, 1'b0, 64'd0);
    wreg(2'd0, 1'b1, 1'b0, 64'd1);
    serve(127, 8'h0B, 1'b0, 1'b0);
    rreg(2'd3, v);
    chk(v == 64'd0, "R5 wrap to zero", v, 64'd0);

    // R2 producer at the length is out of range
    wreg(2'd2, 1'b1, 1'b0, 64'd128 << 5);
    quiet(20, "R2 out of range producer");

    // R2 two pages double the length
    wreg(2'd0, 1'b1, 1'b0, 64'd0);
    wreg(2'd1, 1'b1, 1'b0, base0 | 64'd1);
    len_exp = 256;
    wreg(2'd3, 1'b1, 1'b0, 64'd127 << 5);
    wreg(2'd2, 1'b1, 1'b0, 64'd128 << 5);
    wreg(2'd0, 1'b1, 1'b0, 64'd1);
    serve(127, 8'h0A, 1'b0, 1'b0);
    rreg(2'd3, v);
    chk(v == (64'd128 << 5), "R2 length from page count", v, 64'd128 << 5);

    // R4 R11 sweep over every opcode, wrapping the whole ring once (R5)
    for (int op = 0; op < 256; op++) begin
      int idx;
      idx = (128 + op) % 256;
      wreg(2'd2, 1'b1, 1'b0, 64'((idx + 1) % 256) << 5);
      serve(idx, 8'(op), 1'b0, 1'b0);
    end
    rreg(2'd3, v);
    chk(v == (64'd128 << 5), "R5 full lap returns to start", v, 64'd128 << 5);
    quiet(10, "R12 idle after sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule